// File: doc/BRIEF.md
# SPI Master Serial Engine

This block is the bit-level engine of a byte-wide SPI master. It pulls bytes from an external transmit queue through a valid/ready pop port and shifts each one out most-significant bit first on `mosi`. At the same time it assembles the byte arriving on `miso` and offers it to an external receive queue through a valid/ready push port. It also drives four active-low chip-select lines. A surrounding register file supplies one 17-bit configuration word and a separate global enable.

The serial clock is the reference clock divided by a power of two chosen by a 3-bit code. Clock polarity and phase are captured only while the global enable is low, so the idle level cannot move while the engine runs. The chip-select field can be used in two ways. It can drive the lines directly as an active-low one-hot pattern. It can also hold a binary slave number, which the block decodes. The lines can be held at the field value at all times, or asserted only for the length of a burst.

A transfer starts when the transmit queue has data. If manual start is enabled, it waits instead for a software start strobe. If an external master pulls the slave-select input low, the engine reports a mode fault, abandons the byte in flight and waits for the global enable to be cycled.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset `sclk` is 0, `mosi` is 0, `rx_valid`, `tx_ready`, `tx_full` and `mode_fault` are 0, and with the reset configuration word 0x07C09 `cs_n` is 4'hF.
- R2: A byte is shifted out MSB first over exactly 16 `sclk` transitions, and `sclk` returns to the latched idle level (CPOL, config bit 1) afterwards.
- R3: Every `sclk` half period lasts 2^code reference cycles, where code is config bits 5:3. A code of 0 behaves as code 1.
- R4: With CPHA (config bit 2) = 0, `mosi` is valid before the first edge and `miso` is sampled on odd-numbered edges (1st, 3rd, ...). With CPHA = 1, data changes on odd-numbered edges and is sampled on even-numbered edges. The received byte appears on `rx_data`.
- R5: CPOL and CPHA are captured only while `en` is low. Changing them while `en` is high has no effect until `en` falls and rises again.
- R6: With decoded mode (config bit 9) off, `cs_n` equals the chip-select field (config bits 13:10) whenever the lines are asserted.
- R7: With decoded mode on, line n (n = 0..3) is low exactly when the field equals n. Any other field value leaves all lines high.
- R8: With force (config bit 14) off, `cs_n` is 4'hF outside a burst. The selected lines stay asserted from the first byte's load to the last byte's end, including the gaps between bytes.
- R9: A byte is popped (`tx_ready` high with `tx_valid`) only when `en` and the master bit (config bit 0) are both set, no byte is shifting and no received byte is blocked.
- R10: With manual start enable (config bit 15) set, a waiting byte does not start. A 0-to-1 change of config bit 16 starts a run, which continues until the transmit port is empty. A further run needs a new 0-to-1 change.
- R11: A low `ss_in_n` while enabled as master gives a one-cycle `mode_fault` pulse. It aborts the byte without `rx_valid`, returns `sclk` to idle, releases the chip-selects, and blocks new bytes until `en` is cycled.
- R12: `rx_valid` and `rx_data` hold until `rx_ready`. No new byte is popped while a received byte is blocked.
- R13: `tx_full` is high while `tx_valid` is high and the engine cannot pop.
- R14: With `en` low or the master bit clear, no byte is popped and `sclk` stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global enable; CPOL/CPHA are captured while low |
| cfg | input | 17 | Configuration word |
| tx_valid | input | 1 | Transmit queue holds a byte |
| tx_data | input | 8 | Byte at the head of the transmit queue |
| tx_ready | output | 1 | Pop strobe for the transmit queue |
| tx_full | output | 1 | A byte is waiting but cannot be taken |
| rx_valid | output | 1 | Received byte available |
| rx_data | output | 8 | Received byte |
| rx_ready | input | 1 | Receive queue accepts the byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip-select lines |
| ss_in_n | input | 1 | External slave-select sense; low signals another master |
| mode_fault | output | 1 | One-cycle fault pulse |

## Verification
`tx_ready`, `tx_full` and `cs_n` are combinational, so the bench reads them in the same cycle it changes an input, after a short settling delay. The first `sclk` edge comes 2^code cycles after the pop edge and the following edges come at the same spacing. `rx_valid` rises at the clock edge that makes the sixteenth transition, together with the chip-select release at the end of a burst. `mode_fault` is visible one cycle after `ss_in_n` falls. The bench drives inputs and samples outputs on falling clock edges. Its slave model reacts to each `sclk` change on the falling edge that follows, so the bench waits one more falling edge before it reads the slave model's edge counts and captured bits.

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [16:0]       cfg,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              tx_full,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic              rx_ready,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [3:0]        cs_n,
  input  logic              ss_in_n,
  output logic              mode_fault
);
  localparam int B_MEN  = 0;
  localparam int B_CPOL = 1;
  localparam int B_CPHA = 2;
  localparam int B_DIV  = 3;
  localparam int B_DEC  = 9;
  localparam int B_CS   = 10;
  localparam int B_FRC  = 14;
  localparam int B_MSE  = 15;
  localparam int B_MST  = 16;
  localparam int HALF_W = 2 ** CODE_W;
  localparam int EDGES  = 2 * DATA_W;
  localparam int EC_W   = $clog2(EDGES);

  logic              cpol_l, cpha_l;
  logic              shifting_q, burst_q, run_q, mst_q, halt_q, fault_q;
  logic              rxv_q, mosi_q, sclk_q;
  logic [DATA_W-1:0] sh_q, rx_q, rxd_q;
  logic [HALF_W-1:0] div_q, half_q;
  logic [EC_W-1:0]   edge_q;
  logic [3:0]        sel_n;

  logic cfg_unused;
  assign cfg_unused = ^cfg[8:6];

  wire              active     = en & cfg[B_MEN];
  wire              fault_cond = active & ~ss_in_n;
  wire [CODE_W-1:0] code       = cfg[B_DIV +: CODE_W];
  wire [CODE_W-1:0] code_eff   = (code == '0) ? CODE_W'(1) : code;
  wire [3:0]        field      = cfg[B_CS +: 4];
  wire              go         = cfg[B_MSE] ? run_q : 1'b1;
  wire              can_start  = active & ~shifting_q & ~halt_q & ~fault_cond &
                                 tx_valid & go & (~rxv_q | rx_ready);
  wire              tick       = shifting_q & (div_q == half_q - 1'b1);
  wire              leading    = ~edge_q[0];
  wire              last       = (edge_q == EC_W'(EDGES - 1));
  wire              samp       = tick & (leading ^ cpha_l);
  wire              drv        = tick & ~(leading ^ cpha_l) & ~last;
  wire [DATA_W-1:0] rx_next    = {rx_q[DATA_W-2:0], miso};

  assign tx_ready   = can_start;
  assign tx_full    = tx_valid & ~can_start;
  assign rx_valid   = rxv_q;
  assign rx_data    = rxd_q;
  assign sclk       = sclk_q;
  assign mosi       = mosi_q;
  assign mode_fault = fault_q;

  always_comb begin
    if (cfg[B_DEC]) begin
      for (int i = 0; i < 4; i++) sel_n[i] = ~(field == 4'(i));
    end else begin
      sel_n = field;
    end
  end

  assign cs_n = (cfg[B_FRC] | burst_q) ? sel_n : 4'hF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpol_l     <= 1'b0;
      cpha_l     <= 1'b0;
      shifting_q <= 1'b0;
      burst_q    <= 1'b0;
      run_q      <= 1'b0;
      mst_q      <= 1'b0;
      halt_q     <= 1'b0;
      fault_q    <= 1'b0;
      rxv_q      <= 1'b0;
      mosi_q     <= 1'b0;
      sclk_q     <= 1'b0;
      sh_q       <= '0;
      rx_q       <= '0;
      rxd_q      <= '0;
      div_q      <= '0;
      half_q     <= '0;
      edge_q     <= '0;
    end else begin
      mst_q <= cfg[B_MST];
      if (cfg[B_MST] & ~mst_q) run_q <= 1'b1;
      else if (~shifting_q & ~tx_valid) run_q <= 1'b0;

      if (!en) begin
        cpol_l <= cfg[B_CPOL];
        cpha_l <= cfg[B_CPHA];
        halt_q <= 1'b0;
      end else if (fault_cond) begin
        halt_q <= 1'b1;
      end
      fault_q <= fault_cond & ~halt_q;

      if (rxv_q & rx_ready) rxv_q <= 1'b0;

      if (!active || fault_cond) begin
        shifting_q <= 1'b0;
        burst_q    <= 1'b0;
        sclk_q     <= en ? cpol_l : cfg[B_CPOL];
      end else if (can_start) begin
        shifting_q <= 1'b1;
        burst_q    <= 1'b1;
        div_q      <= '0;
        edge_q     <= '0;
        rx_q       <= '0;
        half_q     <= HALF_W'(1) << code_eff;
        if (cpha_l) begin
          sh_q <= tx_data;
        end else begin
          mosi_q <= tx_data[DATA_W-1];
          sh_q   <= {tx_data[DATA_W-2:0], 1'b0};
        end
      end else if (tick) begin
        div_q  <= '0;
        edge_q <= edge_q + 1'b1;
        sclk_q <= ~sclk_q;
        if (samp) rx_q <= rx_next;
        if (drv) begin
          mosi_q <= sh_q[DATA_W-1];
          sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
        end
        if (last) begin
          shifting_q <= 1'b0;
          rxv_q      <= 1'b1;
          rxd_q      <= samp ? rx_next : rx_q;
          if (!(tx_valid & go)) burst_q <= 1'b0;
        end
      end else if (shifting_q) begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !shifting_q) |-> (sclk_q == cpol_l));

  // R5
  mode_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && en) |-> ($stable(cpol_l) && $stable(cpha_l)));

  // R9
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    can_start |=> shifting_q);

  // R10
  man_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[B_MSE] && !run_q) |-> !tx_ready);

  // R11
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> !fault_q);

  // R12
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxv_q && !rx_ready) |=> (rxv_q && $stable(rxd_q)));
endmodule

// File: tb/spi_shift_engine_bench.sv
module spi_shift_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [16:0] CFG_RST = 17'h07C09;
  // {cpol, cpha, code[2:0], field[3:0], tx[7:0], rx[7:0]}
  localparam logic [24:0] VEC [6] = '{
    {1'b0, 1'b0, 3'd1, 4'hE, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 3'd2, 4'hD, 8'h5A, 8'hC3},
    {1'b1, 1'b0, 3'd1, 4'hB, 8'h81, 8'h7E},
    {1'b1, 1'b1, 3'd3, 4'h7, 8'hFF, 8'h00},
    {1'b0, 1'b0, 3'd0, 4'hE, 8'h00, 8'hFF},
    {1'b1, 1'b1, 3'd7, 4'hD, 8'hC6, 8'h39}
  };

  logic clk = 0, rst_n = 0, en = 0, tx_valid = 0, rx_ready = 1, miso = 0, ss_in_n = 1;
  logic [16:0] cfg = CFG_RST;
  logic [7:0] tx_data = 0;
  logic tx_ready, tx_full, rx_valid, sclk, mosi, mode_fault;
  logic [7:0] rx_data;
  logic [3:0] cs_n;

  int n_chk = 0, n_bad = 0;
  logic [7:0] b_tx [4];

  logic [7:0] s_resp = 0;
  bit s_cpha = 0;
  int s_edges = 0, s_cnt = 0, s_hmin = 0, s_hmax = 0;
  logic [31:0] s_cap = 0;
  logic s_prev = 0;

  spi_shift_engine u_spi_shift_engine (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg(cfg),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .tx_full(tx_full),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n),
    .ss_in_n(ss_in_n), .mode_fault(mode_fault)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [16:0] mk(bit men, bit cpol, bit cpha, logic [2:0] code,
                                     bit dec, logic [3:0] field, bit frc, bit mse, bit mst);
    logic [16:0] c;
    c = '0;
    c[0] = men; c[1] = cpol; c[2] = cpha; c[5:3] = code; c[9] = dec;
    c[13:10] = field; c[14] = frc; c[15] = mse; c[16] = mst;
    return c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic slave_run();
    forever begin
      @(negedge clk);
      s_cnt++;
      if (sclk !== s_prev) begin
        bit lead;
        lead = (s_edges % 2) == 0;
        if (s_edges % 16 != 0) begin
          if (s_cnt < s_hmin) s_hmin = s_cnt;
          if (s_cnt > s_hmax) s_hmax = s_cnt;
        end
        s_cnt = 0;
        if (lead == !s_cpha) s_cap = {s_cap[30:0], mosi};
        if (!s_cpha && !lead) miso = s_resp[7 - (((s_edges + 1) / 2) % 8)];
        if (s_cpha && lead) miso = s_resp[7 - ((s_edges / 2) % 8)];
        s_edges++;
        s_prev = sclk;
      end
    end
  endtask

  task automatic slave_clear(input logic [7:0] resp, input bit cpha);
    s_resp = resp; s_cpha = cpha; s_edges = 0; s_cnt = 0;
    s_hmin = 99999; s_hmax = 0; s_cap = 0; s_prev = sclk; miso = resp[7];
  endtask

  task automatic configure(input logic [16:0] c);
    @(negedge clk); en = 0; cfg = c;
    @(negedge clk); @(negedge clk); en = 1;
    @(negedge clk);
  endtask

  task automatic run_burst(input int n, input logic [3:0] cs_mid, input logic [3:0] cs_end,
                           input string tag);
    tx_data = b_tx[0]; tx_valid = 1;
    #1;
    for (int i = 0; i < n; i++) begin
      int t;
      t = 0;
      while (!tx_ready && t < 5000) begin @(negedge clk); t++; end
      if (t >= 5000) chk({tag, " R9 pop timeout"}, 0, 1);
      @(negedge clk);
      if (i + 1 < n) begin
        tx_data = b_tx[i + 1];
        chk({tag, " R13 tx_full while shifting"}, tx_full, 1);
      end else begin
        tx_valid = 0;
      end
      t = 0;
      while (!rx_valid && t < 5000) begin @(negedge clk); t++; end
      chk({tag, " R4 rx byte"}, rx_data, s_resp);
      chk({tag, " R8 cs_n at byte end"}, cs_n, (i + 1 < n) ? cs_mid : cs_end);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R9 run did not finish actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt, cnt2, cnt3;
    fork slave_run(); join_none

    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 sclk", sclk, 0);
    chk("R1 mosi", mosi, 0);
    chk("R1 cs_n", cs_n, 4'hF);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 tx_ready", tx_ready, 0);
    chk("R1 tx_full", tx_full, 0);
    chk("R1 mode_fault", mode_fault, 0);

    for (int i = 0; i < 6; i++) begin
      logic cpol, cpha;
      logic [2:0] code;
      logic [3:0] field;
      logic [7:0] tx, rx;
      int half;
      {cpol, cpha, code, field, tx, rx} = VEC[i];
      half = 1 << ((code == 0) ? 1 : code);
      configure(mk(1, cpol, cpha, code, 0, field, 0, 0, 0));
      chk("R2 idle level before", sclk, cpol);
      chk("R8 cs_n idle", cs_n, 4'hF);
      slave_clear(rx, cpha);
      b_tx[0] = tx;
      run_burst(1, field, 4'hF, "vector R6");
      chk("R2 msb-first byte", s_cap[7:0], tx);
      chk("R2 edge count", s_edges, 16);
      chk("R3 min half period", s_hmin, half);
      chk("R3 max half period", s_hmax, half);
      chk("R2 idle level after", sclk, cpol);
    end

    configure(mk(1, 0, 0, 1, 0, 4'hE, 0, 0, 0));
    cfg = mk(1, 1, 1, 1, 0, 4'hE, 0, 0, 0);
    repeat (4) @(negedge clk);
    chk("R5 cpol ignored while enabled", sclk, 0);
    slave_clear(8'h69, 0);
    b_tx[0] = 8'h96;
    run_burst(1, 4'hE, 4'hF, "R5");
    chk("R5 old phase kept", s_cap[7:0], 8'h96);
    en = 0; @(negedge clk); @(negedge clk); en = 1; @(negedge clk);
    chk("R5 new polarity after enable cycle", sclk, 1);

    configure(mk(1, 0, 1, 2, 0, 4'hD, 0, 0, 0));
    slave_clear(8'h5C, 1);
    b_tx[0] = 8'h11; b_tx[1] = 8'h22; b_tx[2] = 8'h33;
    run_burst(3, 4'hD, 4'hF, "burst R8");
    chk("R8 burst bytes", s_cap[23:0], 24'h112233);
    chk("R2 burst edges", s_edges, 48);

    cfg = mk(1, 0, 0, 1, 1, 4'd2, 1, 0, 0); @(negedge clk);
    chk("R7 decoded 2", cs_n, 4'b1011);
    cfg = mk(1, 0, 0, 1, 1, 4'd5, 1, 0, 0); @(negedge clk);
    chk("R7 decoded 5 none", cs_n, 4'hF);
    cfg = mk(1, 0, 0, 1, 1, 4'd0, 1, 0, 0); @(negedge clk);
    chk("R7 decoded 0", cs_n, 4'b1110);
    cfg = mk(1, 0, 0, 1, 1, 4'hF, 1, 0, 0); @(negedge clk);
    chk("R7 decoded F none", cs_n, 4'hF);
    cfg = mk(1, 0, 0, 1, 0, 4'b1010, 1, 0, 0); @(negedge clk);
    chk("R6 forced raw field", cs_n, 4'b1010);
    configure(mk(1, 0, 0, 1, 1, 4'd3, 0, 0, 0));
    slave_clear(8'hE1, 0);
    b_tx[0] = 8'h1E;
    run_burst(1, 4'b0111, 4'hF, "decoded R7");

    configure(mk(1, 0, 0, 1, 0, 4'hE, 0, 1, 0));
    slave_clear(8'hA0, 0);
    tx_data = 8'h0F; tx_valid = 1;
    cnt = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); if (tx_ready) cnt++; end
    chk("R10 no start without strobe", cnt, 0);
    chk("R13 tx_full when held", tx_full, 1);
    chk("R10 no clock without strobe", s_edges, 0);
    cfg = mk(1, 0, 0, 1, 0, 4'hE, 0, 1, 1);
    b_tx[0] = 8'h0F; b_tx[1] = 8'hF0;
    run_burst(2, 4'hE, 4'hF, "manual R10");
    chk("R10 run sent both bytes", s_cap[15:0], 16'h0FF0);
    tx_valid = 1; cnt = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); if (tx_ready) cnt++; end
    chk("R10 run ended when empty", cnt, 0);
    tx_valid = 0;

    configure(mk(1, 0, 0, 3, 0, 4'hE, 0, 0, 0));
    slave_clear(8'h77, 0);
    tx_data = 8'h55; tx_valid = 1;
    #1;
    while (!tx_ready) @(negedge clk);
    repeat (20) @(negedge clk);
    ss_in_n = 0;
    cnt = 0; cnt2 = 0; cnt3 = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (k == 3) ss_in_n = 1;
      if (mode_fault) cnt++;
      if (rx_valid) cnt2++;
      if (tx_ready) cnt3++;
    end
    chk("R11 single fault pulse", cnt, 1);
    chk("R11 no rx after abort", cnt2, 0);
    chk("R11 no pop while halted", cnt3, 0);
    chk("R11 sclk idle after abort", sclk, 0);
    chk("R11 cs released", cs_n, 4'hF);
    chk("R13 tx_full while halted", tx_full, 1);
    en = 0; @(negedge clk); en = 1;
    #1;
    cnt = 0;
    while (!tx_ready && cnt < 100) begin @(negedge clk); cnt++; end
    chk("R11 resumes after enable cycle", tx_ready, 1);
    @(negedge clk); tx_valid = 0;
    cnt = 0;
    while (!rx_valid && cnt < 500) begin @(negedge clk); cnt++; end
    @(negedge clk);

    configure(mk(1, 0, 0, 1, 0, 4'hE, 0, 0, 0));
    rx_ready = 0;
    slave_clear(8'h3A, 0);
    tx_data = 8'hC5; tx_valid = 1;
    #1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk); tx_data = 8'h5C;
    while (!rx_valid) @(negedge clk);
    cnt = 0; cnt2 = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (!rx_valid || rx_data !== 8'h3A) cnt++;
      if (tx_ready) cnt2++;
    end
    chk("R12 rx held", cnt, 0);
    chk("R12 no pop while blocked", cnt2, 0);
    rx_ready = 1;
    #1;
    chk("R12 pop on release", tx_ready, 1);
    @(negedge clk); tx_valid = 0;
    chk("R12 rx_valid cleared", rx_valid, 0);
    while (!rx_valid) @(negedge clk);
    @(negedge clk);
    chk("R12 both bytes sent", s_cap[15:0], 16'hC55C);

    configure(mk(0, 0, 0, 1, 0, 4'hE, 0, 0, 0));
    slave_clear(8'h00, 0);
    tx_data = 8'hAA; tx_valid = 1;
    cnt = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (tx_ready) cnt++; end
    chk("R14 master bit clear no pop", cnt, 0);
    en = 0; cfg = mk(1, 0, 0, 1, 0, 4'hE, 0, 0, 0);
    cnt = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (tx_ready) cnt++; end
    chk("R14 enable low no pop", cnt, 0);
    chk("R14 no clock edges", s_edges, 0);
    tx_valid = 0;

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule